// File: doc/BRIEF.md
# 32-Pin Parallel IO Bank Controller

The block manages one bank of 32 pads. Each pad is owned either by the block's own general-purpose logic or by one of two peripheral functions, A or B. Software sets the pad's attributes through a small word-addressed register port: ownership, which peripheral owns the pad, output enable, output data, pull-up, an input glitch filter, open-drain drive and an interrupt mask. Every attribute has a write-ones-to-set address and a write-ones-to-clear address, so software can change one pin without a read-modify-write. Each attribute also has an address that reads it back.

Pad inputs pass through a two-flop synchronizer and, where enabled, a filter. The accepted level can always be read, whatever owns the pad. A change in either direction of the accepted level is latched into an event status word. Reading that word returns it and clears it. The single interrupt output is raised while any latched event is also unmasked.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, ownership reads all ones (GPIO on every pin) and pull-up reads all ones. Output enable, data, filter, open-drain, peripheral select, interrupt mask and event status all read zero. `pad_oe` is zero and `pad_pu` is all ones.
- R2: A write of word W to a set address ORs W into that attribute, and a write to its clear address ANDs the attribute with ~W. The word addresses, as set/clear/read, are:
  - ownership 0/1/2
  - output enable 3/4/5
  - data 6/7/8
  - pull-up 9/10/11
  - filter 12/13/14
  - open-drain 15/16/17
  - peripheral select: 18 selects A, 19 selects B, 20 reads back with 1 meaning B
  - interrupt mask: 21 enables, 22 disables, 23 reads back
  - event status reads at 24
  - accepted pad level reads at 25
- R3: Reading any set or clear address, or an unused address, returns zero. A write to a read-only address (2, 20, 24, 25 and the like) changes nothing.
- R4: On a pin owned by GPIO, `pad_out` follows the data bit and `pad_oe` follows the output-enable bit.
- R5: On a pin not owned by GPIO, `pad_out` and `pad_oe` come from peripheral A when the select bit is 0 and from peripheral B when it is 1.
- R6: On an open-drain pin, `pad_out` is 0. `pad_oe` is the enable of the selected source ANDed with the inverse of its drive value.
- R7: `pad_pu` equals the pull-up attribute bit for bit.
- R8: A pad level change, with the filter off, appears in the pad-level read after the third rising clock edge. This holds whatever owns the pin.
- R9: With the filter on, a pad pulse one cycle long is never accepted. A level held for at least two cycles is accepted one cycle later than it would be with the filter off.
- R10: Every rising or falling change of the accepted level sets the pin's event status bit. A read of address 24 returns the bits and clears them. An event arriving in the cycle of the read is kept.
- R11: `irq` is high exactly when some event status bit is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (clears event status at address 24) |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pad pull-up enables |
| pera_out | input | 32 | Peripheral A drive values |
| pera_oe | input | 32 | Peripheral A enables |
| perb_out | input | 32 | Peripheral B drive values |
| perb_oe | input | 32 | Peripheral B enables |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that address, write data and strobes are stable across the rising edge on which they are sampled. They also assume that a read of the event status lasts one cycle per intended read, since every cycle with the strobe high clears it. The stimulus changes every input on the falling edge and pulses each strobe for exactly one cycle. Pad inputs start low through reset, so no event is latched before the test begins.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_re,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  input  logic [NPIN-1:0] pera_out,
  input  logic [NPIN-1:0] pera_oe,
  input  logic [NPIN-1:0] perb_out,
  input  logic [NPIN-1:0] perb_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_OWN_S = AW'(0),  A_OWN_C = AW'(1),  A_OWN_R = AW'(2);
  localparam logic [AW-1:0] A_OE_S  = AW'(3),  A_OE_C  = AW'(4),  A_OE_R  = AW'(5);
  localparam logic [AW-1:0] A_DAT_S = AW'(6),  A_DAT_C = AW'(7),  A_DAT_R = AW'(8);
  localparam logic [AW-1:0] A_PU_S  = AW'(9),  A_PU_C  = AW'(10), A_PU_R  = AW'(11);
  localparam logic [AW-1:0] A_FLT_S = AW'(12), A_FLT_C = AW'(13), A_FLT_R = AW'(14);
  localparam logic [AW-1:0] A_OD_S  = AW'(15), A_OD_C  = AW'(16), A_OD_R  = AW'(17);
  localparam logic [AW-1:0] A_SEL_A = AW'(18), A_SEL_B = AW'(19), A_SEL_R = AW'(20);
  localparam logic [AW-1:0] A_MSK_S = AW'(21), A_MSK_C = AW'(22), A_MSK_R = AW'(23);
  localparam logic [AW-1:0] A_EVT   = AW'(24), A_LVL   = AW'(25);

  logic [NPIN-1:0] own, oe, dat, pu, flt, od, sel, msk, isr;
  logic [NPIN-1:0] s1, s2, s3, lvl, lvl_d, lvl_n, vsrc, esrc;

  wire evt_rd = bus_re && (bus_addr == A_EVT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= '1; oe <= '0; dat <= '0; pu <= '1;
      flt <= '0; od <= '0; sel <= '0; msk <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OWN_S: own <= own | bus_wdata;
        A_OWN_C: own <= own & ~bus_wdata;
        A_OE_S:  oe  <= oe  | bus_wdata;
        A_OE_C:  oe  <= oe  & ~bus_wdata;
        A_DAT_S: dat <= dat | bus_wdata;
        A_DAT_C: dat <= dat & ~bus_wdata;
        A_PU_S:  pu  <= pu  | bus_wdata;
        A_PU_C:  pu  <= pu  & ~bus_wdata;
        A_FLT_S: flt <= flt | bus_wdata;
        A_FLT_C: flt <= flt & ~bus_wdata;
        A_OD_S:  od  <= od  | bus_wdata;
        A_OD_C:  od  <= od  & ~bus_wdata;
        A_SEL_A: sel <= sel & ~bus_wdata;
        A_SEL_B: sel <= sel | bus_wdata;
        A_MSK_S: msk <= msk | bus_wdata;
        A_MSK_C: msk <= msk & ~bus_wdata;
        default: ;
      endcase
    end
  end

  assign lvl_n = (~flt & s2) | (flt & (((s2 ~^ s3) & s2) | ((s2 ^ s3) & lvl)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; lvl <= '0; lvl_d <= '0; isr <= '0;
    end else begin
      s1    <= pad_in;
      s2    <= s1;
      s3    <= s2;
      lvl   <= lvl_n;
      lvl_d <= lvl;
      isr   <= (evt_rd ? '0 : isr) | (lvl ^ lvl_d);
    end
  end

  assign vsrc    = (own & dat) | (~own & ((sel & perb_out) | (~sel & pera_out)));
  assign esrc    = (own & oe)  | (~own & ((sel & perb_oe)  | (~sel & pera_oe)));
  assign pad_out = vsrc & ~od;
  assign pad_oe  = esrc & ~(od & vsrc);
  assign pad_pu  = pu;
  assign irq     = |(isr & msk);

  always_comb begin
    case (bus_addr)
      A_OWN_R: bus_rdata = own;
      A_OE_R:  bus_rdata = oe;
      A_DAT_R: bus_rdata = dat;
      A_PU_R:  bus_rdata = pu;
      A_FLT_R: bus_rdata = flt;
      A_OD_R:  bus_rdata = od;
      A_SEL_R: bus_rdata = sel;
      A_MSK_R: bus_rdata = msk;
      A_EVT:   bus_rdata = isr;
      A_LVL:   bus_rdata = lvl;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic            bus_re,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] oe,
  input logic [NPIN-1:0] od,
  input logic [NPIN-1:0] msk,
  input logic [NPIN-1:0] isr,
  input logic [NPIN-1:0] lvl,
  input logic [NPIN-1:0] lvl_d,
  input logic [NPIN-1:0] pad_out,
  input logic            irq
);
  a_r2_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3)) |=> ((oe & $past(bus_wdata)) == $past(bus_wdata)));

  a_r2_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(4)) |=> ((oe & $past(bus_wdata)) == '0));

  a_r6_od_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((od & pad_out) == '0));

  a_r10_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != lvl_d) |=> ((isr & $past(lvl ^ lvl_d)) == $past(lvl ^ lvl_d)));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == AW'(24)) |=> ((isr & ~$past(lvl ^ lvl_d)) == '0));

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |-> !irq);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPIN(NPIN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_wdata(bus_wdata), .oe(oe), .od(od), .msk(msk), .isr(isr), .lvl(lvl),
  .lvl_d(lvl_d), .pad_out(pad_out), .irq(irq)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = '0;
  logic bus_we = 0, bus_re = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [31:0] pera_out = '0, pera_oe = '0, perb_out = '0, perb_oe = '0;
  logic irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_bank_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pera_out(pera_out),
    .pera_oe(pera_oe), .perb_out(perb_out), .perb_oe(perb_oe), .irq(irq));

  // behavioural reference: attribute words plus a per-pin input history
  logic [31:0] m_own, m_oe, m_dat, m_pu, m_flt, m_od, m_sel, m_msk, m_evt, m_acc, m_acc_prev;
  logic [31:0] m_hist [0:2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own <= '1; m_oe <= '0; m_dat <= '0; m_pu <= '1; m_flt <= '0; m_od <= '0;
      m_sel <= '0; m_msk <= '0; m_evt <= '0; m_acc <= '0; m_acc_prev <= '0;
      m_hist[0] <= '0; m_hist[1] <= '0; m_hist[2] <= '0;
    end else begin
      if (bus_we) begin
        case (int'(bus_addr))
          0: m_own <= m_own | bus_wdata;   1: m_own <= m_own & ~bus_wdata;
          3: m_oe  <= m_oe  | bus_wdata;   4: m_oe  <= m_oe  & ~bus_wdata;
          6: m_dat <= m_dat | bus_wdata;   7: m_dat <= m_dat & ~bus_wdata;
          9: m_pu  <= m_pu  | bus_wdata;  10: m_pu  <= m_pu  & ~bus_wdata;
          12: m_flt <= m_flt | bus_wdata; 13: m_flt <= m_flt & ~bus_wdata;
          15: m_od  <= m_od  | bus_wdata; 16: m_od  <= m_od  & ~bus_wdata;
          18: m_sel <= m_sel & ~bus_wdata; 19: m_sel <= m_sel | bus_wdata;
          21: m_msk <= m_msk | bus_wdata; 22: m_msk <= m_msk & ~bus_wdata;
          default: ;
        endcase
      end
      m_hist[0] <= pad_in; m_hist[1] <= m_hist[0]; m_hist[2] <= m_hist[1];
      for (int i = 0; i < 32; i++)
        if (!m_flt[i] || m_hist[1][i] == m_hist[2][i]) m_acc[i] <= m_hist[1][i];
      m_acc_prev <= m_acc;
      m_evt <= ((bus_re && bus_addr == 5'd24) ? 32'h0 : m_evt) | (m_acc ^ m_acc_prev);
    end
  end

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      2: return m_own;  5: return m_oe;  8: return m_dat; 11: return m_pu;
      14: return m_flt; 17: return m_od; 20: return m_sel; 23: return m_msk;
      24: return m_evt; 25: return m_acc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] eo, ee;
    for (int i = 0; i < 32; i++) begin
      logic v, e;
      v = m_own[i] ? m_dat[i] : (m_sel[i] ? perb_out[i] : pera_out[i]);
      e = m_own[i] ? m_oe[i]  : (m_sel[i] ? perb_oe[i]  : pera_oe[i]);
      eo[i] = m_od[i] ? 1'b0 : v;
      ee[i] = m_od[i] ? (e & ~v) : e;
    end
    chk("R4 R5 R6 pad_out", pad_out, eo);
    chk("R4 R5 R6 pad_oe", pad_oe, ee);
    chk("R7 pad_pu", pad_pu, m_pu);
    chk("R11 irq", {31'h0, irq}, {31'h0, |(m_evt & m_msk)});
    if (bus_re) chk("R2 R3 R10 rdata", bus_rdata, exp_rd(int'(bus_addr)));
  endtask

  task automatic tick();
    #1 compare_all();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
    tick();
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    bus_re = 1; bus_addr = 5'(a);
    #1 chk(tag, bus_rdata, e);
    tick();
    bus_re = 0;
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(2, 32'hFFFF_FFFF, "R1 own");   rd(5, 0, "R1 oe");   rd(8, 0, "R1 dat");
    rd(11, 32'hFFFF_FFFF, "R1 pu");   rd(14, 0, "R1 flt"); rd(17, 0, "R1 od");
    rd(20, 0, "R1 sel"); rd(23, 0, "R1 msk"); rd(24, 0, "R1 evt");
    chk("R1 pad_oe", pad_oe, 0); chk("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
    // R3
    rd(0, 0, "R3 set addr"); rd(4, 0, "R3 clr addr"); rd(31, 0, "R3 unused");
    wr(20, 32'hFFFF); rd(20, 0, "R3 ro sel");
    wr(2, 32'h1); rd(2, 32'hFFFF_FFFF, "R3 ro own");
    // R2 R4
    wr(3, 32'hFF); wr(6, 32'h0F);
    rd(5, 32'hFF, "R2 oe set"); rd(8, 32'h0F, "R2 dat set");
    chk("R4 pad_out", pad_out & 32'hFF, 32'h0F); chk("R4 pad_oe", pad_oe, 32'hFF);
    wr(4, 32'h0F); rd(5, 32'hF0, "R2 oe clr");
    wr(7, 32'h03); rd(8, 32'h0C, "R2 dat clr");
    // R5
    pera_out = 32'hAA00; pera_oe = 32'hFFFF_FFFF; perb_out = 32'h5500; perb_oe = 32'h0000_F000;
    wr(1, 32'hFF00); rd(2, 32'hFFFF_00FF, "R2 own clr");
    chk("R5 periph A", pad_out[15:8], 8'hAA);
    wr(19, 32'hF000); rd(20, 32'hF000, "R5 sel B");
    chk("R5 mixed A/B", pad_out[15:8], 8'h5A);
    chk("R5 oe mixed", pad_oe[15:8], 8'hFF);
    wr(18, 32'h1000); rd(20, 32'hE000, "R5 sel A");
    // R6
    wr(15, 32'h0F); wr(3, 32'h0F); rd(17, 32'h0F, "R6 od");
    chk("R6 od out", pad_out[3:0], 4'h0); chk("R6 od oe", pad_oe[3:0], 4'h3);
    // R7
    wr(10, 32'hFFFF_0000); chk("R7 pu clr", pad_pu, 32'h0000_FFFF);
    wr(9, 32'h0001_0000);  chk("R7 pu set", pad_pu, 32'h0001_FFFF);
    // R8: pin 20 is GPIO, pin 9 is peripheral
    pad_in = 32'h0010_0200;
    tick(); tick();
    rd(25, 0, "R8 not yet");
    rd(25, 32'h0010_0200, "R8 level");
    tick();
    // R10
    rd(24, 32'h0010_0200, "R10 evt both pins");
    rd(24, 0, "R10 cleared");
    // R9: one-cycle glitch on filtered pin 5 and unfiltered pin 7
    wr(12, 32'h20); rd(14, 32'h20, "R2 flt set");
    pad_in = 32'h0010_02A0; tick(); pad_in = 32'h0010_0200;
    repeat (6) tick();
    rd(25, 32'h0010_0200, "R9 glitch gone");
    rd(24, 32'h80, "R9 only unfiltered glitch");
    pad_in = 32'h0010_0220;
    tick(); tick(); tick();
    rd(25, 32'h0010_0200, "R9 filtered late");
    rd(25, 32'h0010_0220, "R9 filtered accepted");
    // R11
    wr(21, 32'h20); rd(23, 32'h20, "R11 mask");
    chk("R11 irq up", {31'h0, irq}, 32'h1);
    rd(24, 32'h20, "R10 evt pin5");
    chk("R11 irq down", {31'h0, irq}, 32'h0);
    wr(22, 32'h20); rd(23, 0, "R11 mask clr");
    // R10 falling edge
    pad_in = 32'h0010_0020;
    repeat (5) tick();
    rd(24, 32'h0000_0200, "R10 falling edge");
    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule